// File: doc/BRIEF.md
# LSB-First Serial Control and Diagnosis Slave

This block is a 16-bit serial slave that a host uses to write a control word and read back a diagnosis word in one exchange. The host lowers chip select, toggles the serial clock sixteen times, and raises chip select again. Each word travels least significant bit first. The slave takes in data on the falling clock edge and moves its outgoing data on the rising edge. A fresh control word takes effect only when chip select goes back high. A frame that does not contain exactly sixteen falling clock edges is thrown away.

All serial inputs pass through two-flop synchronisers into the system clock domain. Edges are found on the synchronised copies, so the serial clock must run well below the system clock.

The outgoing word is taken from a status vector at the moment a frame opens. The one exception is bit 0, which is a latched bus-failure flag. While chip select is low and before the first rising clock edge, the data output shows that flag live, so the host can poll it without sending any clocks. Every chip-select release clears the flag.

The control register drives several outputs:
- switch enables for HS1, HS2, HS3, LS1 and LS2;
- a supervisor enable;
- a one-cycle watchdog trigger pulse.

HS1 can also be gated by an external PWM input.

Top module: `spi_ctrl_slave`

## Requirements
- R1: After reset, ctrl_o is 0, sdo_oe_o is 0, wd_trig_o is 0 and every switch output is 0.
- R2: The sdi_i level at the k-th falling sclk_i edge of a frame (k = 0..15) becomes bit k of ctrl_o once chip select is released.
- R3: ctrl_o does not change while a frame is open. It changes only after chip-select release, within 4 clk cycles.
- R4: A frame with fewer or more than 16 falling sclk_i edges leaves ctrl_o unchanged and produces no watchdog pulse.
- R5: For k = 1..15, sdo_o shows status_i[k] after the k-th rising sclk_i edge of a frame. status_i is captured when chip select falls, so later changes to status_i do not affect the frame.
- R6: While chip select is low and before the first rising sclk_i edge, sdo_o follows the current value of the bus-failure flag.
- R7: A high level on bus_fault_i sets the bus-failure flag. The flag stays set until the next chip-select release, which clears it.
- R8: sdo_oe_o is 0 whenever the synchronised chip select is high, and 1 during a frame.
- R9: Each committed word with bit 0 set produces exactly one single-cycle pulse on wd_trig_o. A committed word with bit 0 clear produces none.
- R10: The control bits map to outputs as follows: hs2_o = bit 2, hs3_o = bit 3, ls1_o = bit 5, ls2_o = bit 6, sup_en_o = bit 7.
- R11: hs1_o = bit 1 AND (NOT bit 11 OR pwm_i). When bit 1 is 0, hs1_o is 0 whatever pwm_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (valid while sdo_oe_o is 1) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| status_i | input | 15 | Diagnosis bits 15:1 |
| bus_fault_i | input | 1 | Sets the bus-failure flag |
| pwm_i | input | 1 | PWM gate for HS1 |
| ctrl_o | output | 16 | Committed control word |
| wd_trig_o | output | 1 | Watchdog trigger pulse |
| hs1_o | output | 1 | HS1 switch enable |
| hs2_o | output | 1 | HS2 switch enable |
| hs3_o | output | 1 | HS3 switch enable |
| ls1_o | output | 1 | LS1 switch enable |
| ls2_o | output | 1 | LS2 switch enable |
| sup_en_o | output | 1 | Supervisor enable |

## Verification
Each kind of wrong internal state shows up at the ports in a predictable place:
- **Edge counter off by one:** the control word does not change after release. This is visible a few cycles after chip select rises.
- **Shift direction or clock edge swapped:** the diagnosis bits come out of sdo_o in the wrong order, during the same frame.
- **Bus-failure flag not cleared:** the first bit of the next frame reads 1.
- **Snapshot timing wrong:** changing status_i in the middle of a frame changes the bits that are read back.

// File: rtl/spi_ctrl_slave.sv
module spi_ctrl_slave #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic [WIDTH-1:1] status_i,
  input  logic             bus_fault_i,
  input  logic             pwm_i,
  output logic [WIDTH-1:0] ctrl_o,
  output logic             wd_trig_o,
  output logic             hs1_o,
  output logic             hs2_o,
  output logic             hs3_o,
  output logic             ls1_o,
  output logic             ls2_o,
  output logic             sup_en_o
);
  localparam int CW   = $clog2(WIDTH + 2);
  localparam int CMAX = WIDTH + 1;

  logic [1:0] csn_sy, sck_sy, sdi_sy;
  logic csn_d, sck_d;
  logic csn_s, sck_s, sdi_s;
  logic cs_fall, cs_rise, sck_rise, sck_fall;

  logic             act_q, shifted_q, wd_q, fault_q;
  logic [WIDTH-1:0] in_q, ctrl_q;
  logic [WIDTH-2:0] out_q;
  logic [CW-1:0]    cnt_q;
  logic             frame_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_sy <= 2'b11;
      sck_sy <= 2'b00;
      sdi_sy <= 2'b00;
      csn_d  <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      csn_sy <= {csn_sy[0], csn_i};
      sck_sy <= {sck_sy[0], sclk_i};
      sdi_sy <= {sdi_sy[0], sdi_i};
      csn_d  <= csn_sy[1];
      sck_d  <= sck_sy[1];
    end
  end

  assign csn_s    = csn_sy[1];
  assign sck_s    = sck_sy[1];
  assign sdi_s    = sdi_sy[1];
  assign cs_fall  = csn_d & ~csn_s;
  assign cs_rise  = ~csn_d & csn_s;
  assign sck_rise = act_q & ~sck_d & sck_s;
  assign sck_fall = act_q & sck_d & ~sck_s;
  assign frame_ok = act_q && (cnt_q == CW'(WIDTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      shifted_q <= 1'b0;
      cnt_q     <= '0;
      in_q      <= '0;
      out_q     <= '0;
    end else if (cs_fall) begin
      act_q     <= 1'b1;
      shifted_q <= 1'b0;
      cnt_q     <= '0;
      out_q     <= status_i;
    end else if (cs_rise) begin
      act_q     <= 1'b0;
      shifted_q <= 1'b0;
    end else begin
      if (sck_fall) begin
        in_q <= {sdi_s, in_q[WIDTH-1:1]};
        if (cnt_q != CW'(CMAX)) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_rise) begin
        if (shifted_q) out_q <= {1'b0, out_q[WIDTH-2:1]};
        shifted_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wd_q   <= 1'b0;
    end else begin
      wd_q <= cs_rise & frame_ok & in_q[0];
      if (cs_rise && frame_ok) ctrl_q <= in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fault_q <= 1'b0;
    else if (cs_rise)     fault_q <= 1'b0;
    else if (bus_fault_i) fault_q <= 1'b1;
  end

  assign sdo_oe_o  = act_q;
  assign sdo_o     = act_q & (shifted_q ? out_q[0] : fault_q);
  assign ctrl_o    = ctrl_q;
  assign wd_trig_o = wd_q;
  assign hs1_o     = ctrl_q[1] & (~ctrl_q[11] | pwm_i);
  assign hs2_o     = ctrl_q[2];
  assign hs3_o     = ctrl_q[3];
  assign ls1_o     = ctrl_q[5];
  assign ls2_o     = ctrl_q[6];
  assign sup_en_o  = ctrl_q[7];

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo_oe_o);

  // R9
  wd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trig_o |=> !wd_trig_o);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ctrl_o));

  // R4
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_ok) |=> ($stable(ctrl_o) && !wd_trig_o));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !cs_rise) |=> fault_q);

  // R11
  always_comb begin
    if (rst_n && !ctrl_q[1]) hs1_off_chk: assert (!hs1_o);
  end
endmodule

// File: tb/spi_ctrl_slave_test.sv
module spi_ctrl_slave_test;
  logic clk = 0, rst_n = 0;
  logic csn_i = 1, sclk_i = 0, sdi_i = 0, bus_fault_i = 0, pwm_i = 0;
  logic [15:1] status_i = '0;
  logic sdo_o, sdo_oe_o, wd_trig_o, hs1_o, hs2_o, hs3_o, ls1_o, ls2_o, sup_en_o;
  logic [15:0] ctrl_o;
  int checks = 0, errors = 0, wd_cnt = 0;

  always #4 clk = ~clk;

  spi_ctrl_slave uut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .status_i(status_i),
    .bus_fault_i(bus_fault_i), .pwm_i(pwm_i), .ctrl_o(ctrl_o),
    .wd_trig_o(wd_trig_o), .hs1_o(hs1_o), .hs2_o(hs2_o), .hs3_o(hs3_o),
    .ls1_o(ls1_o), .ls2_o(ls2_o), .sup_en_o(sup_en_o));

  always @(posedge clk) if (wd_trig_o) wd_cnt <= wd_cnt + 1;

  localparam int NV = 6;
  localparam logic [15:0] WORDS [NV] = '{16'h0603, 16'h00E4, 16'h0802, 16'h3000, 16'h0000, 16'hFFFF};
  localparam logic [15:0] STATS [NV] = '{16'hA5A4, 16'h5A5A, 16'hFFFE, 16'h0002, 16'h8000, 16'h1234};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input logic [15:0] st, input int n,
                       output logic [15:0] rx, output logic [15:0] mid);
    rx = '0;
    status_i = st[15:1];
    wclk(2);
    csn_i = 0;
    wclk(6);
    status_i = ~st[15:1];
    wclk(4);
    for (int i = 0; i < n; i++) begin
      if (i < 16) rx[i] = sdo_o;
      sdi_i = (i < 16) ? w[i] : 1'b0;
      sclk_i = 1;
      wclk(10);
      sclk_i = 0;
      wclk(10);
    end
    wclk(6);
    mid = ctrl_o;
    csn_i = 1;
    wclk(12);
  endtask

  logic [15:0] rx, mid, prev;
  int wd0;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wclk(3);
    rst_n = 1;
    wclk(3);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 oe", sdo_oe_o, 0);
    chk("R1 wd", wd_trig_o, 0);
    chk("R1 switches", {hs1_o, hs2_o, hs3_o, ls1_o, ls2_o, sup_en_o}, 0);

    prev = 16'h0000;
    for (int v = 0; v < NV; v++) begin
      wd0 = wd_cnt;
      frame(WORDS[v], STATS[v], 16, rx, mid);
      chk("R3 mid-frame ctrl", mid, prev);
      chk("R2 ctrl", ctrl_o, WORDS[v]);
      chk("R5 sdo bits", rx, {STATS[v][15:1], 1'b0});
      chk("R9 wd pulses", wd_cnt - wd0, {31'b0, WORDS[v][0]});
      chk("R10 decode", {hs2_o, hs3_o, ls1_o, ls2_o, sup_en_o},
          {WORDS[v][2], WORDS[v][3], WORDS[v][5], WORDS[v][6], WORDS[v][7]});
      chk("R11 hs1 pwm low", hs1_o, WORDS[v][1] & ~WORDS[v][11]);
      chk("R8 oe after release", sdo_oe_o, 0);
      prev = WORDS[v];
    end

    wd0 = wd_cnt;
    frame(16'h0001, 16'h0000, 8, rx, mid);
    chk("R4 short frame ctrl", ctrl_o, 16'hFFFF);
    frame(16'h0001, 16'h0000, 17, rx, mid);
    chk("R4 long frame ctrl", ctrl_o, 16'hFFFF);
    chk("R4 no wd pulse", wd_cnt - wd0, 0);

    csn_i = 0;
    wclk(10);
    chk("R8 oe in frame", sdo_oe_o, 1);
    chk("R6 flag clear", sdo_o, 0);
    bus_fault_i = 1;
    wclk(1);
    bus_fault_i = 0;
    wclk(4);
    chk("R6 live flag", sdo_o, 1);
    csn_i = 1;
    wclk(12);
    frame(16'h0000, 16'h0000, 16, rx, mid);
    chk("R7 cleared on release", rx[0], 0);

    bus_fault_i = 1;
    wclk(1);
    bus_fault_i = 0;
    wclk(20);
    frame(16'h0000, 16'h0000, 16, rx, mid);
    chk("R7 flag held", rx[0], 1);
    frame(16'h0000, 16'h0000, 16, rx, mid);
    chk("R7 flag cleared", rx[0], 0);

    frame(16'h0802, 16'h0000, 16, rx, mid);
    pwm_i = 1;
    wclk(1);
    chk("R11 hs1 follows pwm high", hs1_o, 1);
    pwm_i = 0;
    wclk(1);
    chk("R11 hs1 follows pwm low", hs1_o, 0);
    frame(16'h0002, 16'h0000, 16, rx, mid);
    chk("R11 hs1 without pwm enable", hs1_o, 1);
    frame(16'h0800, 16'h0000, 16, rx, mid);
    pwm_i = 1;
    wclk(1);
    chk("R11 hs1 masked by bit1", hs1_o, 0);
    pwm_i = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule